// File: doc/BRIEF.md
# Relative-Jump Program Counter

This block holds the instruction address of a small sequencer. Each clock edge it does one of four things: it clears to zero, steps forward by one, takes a relative branch, or holds. A controller drives the clear while it is initialising, the step during instruction fetch, and the branch input when a taken conditional jump is being executed.

The branch path is one adder that forms `pc + offset - 1` in a single pass. By the time a jump executes, the fetch step has already moved the counter one past the jump instruction. The minus-one cancels that step, so the offset counts from the jump instruction itself. The 8-bit offset is a two's-complement value and is sign-extended, so a branch can go back by up to 128 or forward by up to 127 from the jump. The counter value is registered and drives the instruction-memory address directly.

Top module: `rel_jump_pc`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0x0000 after that edge.
- R2: When `clr` is high at a rising edge, `pc` becomes 0x0000 after that edge.
- R3: With only `inc` high, `pc` becomes the old `pc` plus one after the edge.
- R4: With `jmp` high and `clr` low, `pc` becomes old `pc` + sext(`jump_ofs`) - 1 after the edge. `jump_ofs` is an 8-bit two's-complement value. For example, 0x05 from 0x0010 gives 0x0014.
- R5: An offset with bit 7 set moves the counter backward. For example, 0x80 (-128) from 0x0100 gives 0x007F, and 0xFF (-1) from 0x0010 gives 0x000E.
- R6: `clr` wins over `jmp` and `inc`: `pc` becomes 0x0000 whatever those inputs are.
- R7: `jmp` wins over `inc`: when both are high, only the relative branch takes effect.
- R8: With `clr`, `inc` and `jmp` all low, `pc` keeps its value.
- R9: Arithmetic wraps modulo 2^16. Stepping from 0xFFFF gives 0x0000, and a branch with offset 0x00 from 0x0000 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear to zero (highest priority) |
| inc | input | 1 | Step forward by one (lowest priority) |
| jmp | input | 1 | Take relative branch by `jump_ofs` minus one |
| jump_ofs | input | 8 | Two's-complement branch offset from the instruction |
| pc | output | 16 | Registered counter value, used as the instruction address |

## Verification
The controls can collide: `jmp` and `inc` may be high in the same cycle, and so may `clr` and either of the others. Directed vectors raise each pair, and all three together, from non-zero counter values so that each wrong priority leads to a different result. The bench judges each cycle against its own reference model, which applies the priority order and uses signed integer arithmetic reduced modulo 65536. Pseudo-random control patterns then cover these overlaps many more times.

// File: rtl/rjpc_pkg.sv
package rjpc_pkg;
  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_JREL = 2'd2,
    PC_ZERO = 2'd3
  } pc_op_e;
endpackage

// File: rtl/rjpc_ctrl.sv
module rjpc_ctrl
  import rjpc_pkg::*;
(
  input  logic   clr,
  input  logic   inc,
  input  logic   jmp,
  output pc_op_e op
);
  always_comb begin
    if (clr)      op = PC_ZERO;
    else if (jmp) op = PC_JREL;
    else if (inc) op = PC_STEP;
    else          op = PC_HOLD;
  end
endmodule

// File: rtl/rjpc_ofs_ext.sv
module rjpc_ofs_ext #(
  parameter int PC_W       = 16,
  parameter int OFS_W      = 8,
  parameter bit OFS_SIGNED = 1'b1
) (
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  ext
);
  localparam int PAD_W = PC_W - OFS_W;

  generate
    if (OFS_SIGNED) begin : g_sext
      assign ext = {{PAD_W{ofs[OFS_W-1]}}, ofs};
    end else begin : g_zext
      assign ext = {{PAD_W{1'b0}}, ofs};
    end
  endgenerate
endmodule

// File: rtl/rjpc_next.sv
module rjpc_next
  import rjpc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  pc_op_e          op,
  input  logic [PC_W-1:0] cur,
  input  logic [PC_W-1:0] ext,
  output logic [PC_W-1:0] nxt
);
  localparam logic [PC_W-1:0] ONE     = PC_W'(1);
  localparam logic [PC_W-1:0] MINUS_1 = {PC_W{1'b1}};

  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] step_tgt;

  // one adder chain: current + offset + all-ones (i.e. -1)
  assign rel_tgt  = cur + ext + MINUS_1;
  assign step_tgt = cur + ONE;

  always_comb begin
    unique case (op)
      PC_ZERO: nxt = '0;
      PC_JREL: nxt = rel_tgt;
      PC_STEP: nxt = step_tgt;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/rel_jump_pc.sv
module rel_jump_pc
  import rjpc_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int OFS_W      = 8,
  parameter bit OFS_SIGNED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             jmp,
  input  logic [OFS_W-1:0] jump_ofs,
  output logic [PC_W-1:0]  pc
);
  pc_op_e          op;
  logic [PC_W-1:0] ext;
  logic [PC_W-1:0] nxt;
  logic [PC_W-1:0] pc_q;

  rjpc_ctrl u_ctrl (
    .clr (clr),
    .inc (inc),
    .jmp (jmp),
    .op  (op)
  );

  rjpc_ofs_ext #(
    .PC_W       (PC_W),
    .OFS_W      (OFS_W),
    .OFS_SIGNED (OFS_SIGNED)
  ) u_ext (
    .ofs (jump_ofs),
    .ext (ext)
  );

  rjpc_next #(
    .PC_W (PC_W)
  ) u_next (
    .op  (op),
    .cur (pc_q),
    .ext (ext),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= nxt;
  end

  assign pc = pc_q;

  // R1
  rst_zero_chk: assert property (@(posedge clk) rst |=> (pc == '0));

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pc == '0));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !jmp && !clr) |=> (pc == PC_W'($past(pc) + 1'b1)));

  // R4
  rel_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (jmp && !clr) |=> (pc == PC_W'($past(pc) + $past(ext) - 1'b1)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !jmp && !clr) |=> $stable(pc));
endmodule

// File: tb/rel_jump_pc_test.sv
`timescale 1ns/1ps
module rel_jump_pc_test;
  logic        clk = 1'b0;
  logic        rst, clr, inc, jmp;
  logic [7:0]  jump_ofs;
  logic [15:0] pc;

  int checks = 0;
  int fails  = 0;
  int model  = 0;

  always #5 clk = ~clk;

  rel_jump_pc uut (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .inc      (inc),
    .jmp      (jmp),
    .jump_ofs (jump_ofs),
    .pc       (pc)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic apply(input logic r, input logic c, input logic i,
                       input logic j, input logic [7:0] o, input string tag);
    int off;
    rst = r; clr = c; inc = i; jmp = j; jump_ofs = o;
    @(posedge clk);
    off = (o >= 8'h80) ? int'(o) - 256 : int'(o);
    if (r || c)   model = 0;
    else if (j)   model = (model + off - 1 + 65536) % 65536;
    else if (i)   model = (model + 1) % 65536;
    #2;
    checks++;
    if (int'(pc) != model) begin
      fails++;
      $display("FAIL %s: pc=%04h expected=%04h", tag, pc, model[15:0]);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: pc=%04h expected=finish", pc);
    report();
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst = 1'b1; clr = 0; inc = 0; jmp = 0; jump_ofs = 0;
    #1;
    apply(1, 0, 0, 0, 8'h00, "R1 reset");
    apply(1, 0, 1, 1, 8'h33, "R1 reset beats controls");
    // R3 stepping
    for (int k = 0; k < 16; k++) apply(0, 0, 1, 0, 8'h00, "R3 step");
    // R8 hold with junk offset
    apply(0, 0, 0, 0, 8'hA5, "R8 hold");
    apply(0, 0, 0, 0, 8'h7F, "R8 hold");
    // R4 forward branch: 0x0010 + 5 - 1 = 0x0014
    apply(0, 0, 0, 1, 8'h05, "R4 forward");
    apply(0, 0, 0, 1, 8'h01, "R4 offset one stays");
    // R5 backward: 0xFF
    apply(0, 0, 0, 1, 8'hFF, "R5 minus one");
    apply(0, 0, 0, 1, 8'h7F, "R4 max forward");
    apply(0, 0, 0, 1, 8'h80, "R5 max backward");
    // R7 jump beats step
    apply(0, 0, 1, 1, 8'h10, "R7 jmp over inc");
    apply(0, 0, 1, 1, 8'hF0, "R7 jmp over inc neg");
    // R6 clear beats everything
    apply(0, 1, 1, 1, 8'h40, "R6 clr over all");
    apply(0, 0, 1, 0, 8'h00, "R3 step");
    apply(0, 0, 1, 0, 8'h00, "R3 step");
    apply(0, 1, 0, 1, 8'h22, "R6 clr over jmp");
    apply(0, 0, 1, 0, 8'h00, "R3 step");
    apply(0, 1, 1, 0, 8'h00, "R6 clr over inc");
    apply(0, 1, 0, 0, 8'h00, "R2 clr");
    // R9 wrap: from 0, offset 0 -> 0xFFFF, then step -> 0
    apply(0, 0, 0, 1, 8'h00, "R9 branch underflow");
    apply(0, 0, 1, 0, 8'h00, "R9 step overflow");
    apply(0, 0, 0, 1, 8'hFE, "R9 backward wrap");
    apply(0, 0, 0, 1, 8'h05, "R9 forward wrap");
    // R5 from 0x0100 with 0x80 -> 0x007F
    apply(0, 1, 0, 0, 8'h00, "R2 clr");
    for (int k = 0; k < 256; k++) apply(0, 0, 1, 0, 8'h00, "R3 step");
    apply(0, 0, 0, 1, 8'h80, "R5 0x80 from 0x100");
    // pseudo-random mix
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      apply(lf[0] & lf[1] & lf[2] & lf[3] & lf[4], lf[5] & lf[6] & lf[7],
            lf[8], lf[9] | lf[3], lf[15:8], "R6 R7 mixed");
    end
    report();
    $finish;
  end
endmodule